// File: doc/BRIEF.md
# Fault-Steering Rotating Memory Wrapper

This wrapper sits between a client and a word-addressed memory whose bit cells may fail. It holds a small fault table with one entry per memory word. Each entry names the segment of that word's physical layout that holds a failing cell. The word is split into `2**SEG_BITS` equal segments of `SEG_W = DATA_W >> SEG_BITS` bits. With `SEG_BITS` equal to log2 of `DATA_W`, each segment is one bit wide, and the failing bit then always stores the logical LSB.

On a write, the client word is rotated left by `entry * SEG_W` bits before it reaches the memory. The logical least significant segment therefore lands on the failing physical segment. On a read, the returned word is rotated right by the same amount. A stuck cell then corrupts only low-significance bits of the two's complement value, and the value is not corrected. The table is loaded at run time through a separate update port by whatever fault-detection procedure the system uses.

Top module: `fault_shuffle_wrap`

## Requirements
- R1: After reset every fault-table entry is 0, and `cl_rvalid` is low until the first read is issued.
- R2: For a write request (`cl_req`=1, `cl_we`=1), in the same cycle `mem_en`=1, `mem_we`=1, `mem_addr`=`cl_addr` and `mem_wdata` = `cl_wdata` rotated left by `entry[cl_addr]*SEG_W` bits, where bit i moves to bit (i+k) mod DATA_W. With no request, `mem_en` is 0.
- R3: A read request (`cl_req`=1, `cl_we`=0) drives `mem_en`=1, `mem_we`=0. The memory returns its data one cycle later. In that cycle `cl_rvalid`=1 and `cl_rdata` = `mem_rdata` rotated right by the issue-time shift. In all other cycles `cl_rvalid`=0.
- R4: A word whose entry is 0 passes through both ways unchanged.
- R5: An update (`fm_wr`=1 with `fm_addr` and `fm_idx`) changes the entry at the clock edge. An access to the same address in the same cycle still uses the old entry, and the next access uses the new entry.
- R6: The read-back rotation is fixed when the read is issued. An update to that address in the issue cycle does not change the data returned for that read.
- R7: With one stuck physical bit at position p and entry p / SEG_W, every read-back value differs from the written value, taken as a signed number, by less than 2**SEG_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cl_req | input | 1 | Client access request |
| cl_we | input | 1 | 1 = write, 0 = read |
| cl_addr | input | ADDR_W | Client word address |
| cl_wdata | input | DATA_W | Client write data, logical order |
| cl_rdata | output | DATA_W | Read data, logical order |
| cl_rvalid | output | 1 | Read data valid, one cycle after the read request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Rotated data to memory |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the request |
| fm_wr | input | 1 | Fault-table update strobe |
| fm_addr | input | ADDR_W | Word whose entry is updated |
| fm_idx | input | SEG_BITS | Segment index holding the failing cell |

## Verification
A table update and a client access can fall in the same cycle, and they can target the same word. The bench provokes this both with a write and with a read in the update cycle. A behavioural model in the bench applies the update only after it has computed that cycle's access, and it compares the memory-side data and the read-back data on every cycle. For the read case, the model also checks that the data returned a cycle later is rotated with the issue-time entry, while the following read uses the new one.

// File: rtl/fault_shuffle_wrap.sv
module fault_shuffle_wrap #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int SEG_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cl_req,
  input  logic                cl_we,
  input  logic [ADDR_W-1:0]   cl_addr,
  input  logic [DATA_W-1:0]   cl_wdata,
  output logic [DATA_W-1:0]   cl_rdata,
  output logic                cl_rvalid,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                fm_wr,
  input  logic [ADDR_W-1:0]   fm_addr,
  input  logic [SEG_BITS-1:0] fm_idx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SEG_W = DATA_W >> SEG_BITS;
  localparam int ROT_W = $clog2(DATA_W);

  logic [SEG_BITS-1:0] fmap [DEPTH];
  logic [ROT_W-1:0]    wr_sh, rd_sh_q;
  logic [2*DATA_W-1:0] wr_dbl, rd_dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fmap[i] <= '0;
    end else if (fm_wr) begin
      fmap[fm_addr] <= fm_idx;
    end
  end

  assign wr_sh = ROT_W'(32'(fmap[cl_addr]) * SEG_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_rvalid <= 1'b0;
      rd_sh_q   <= '0;
    end else begin
      cl_rvalid <= cl_req && !cl_we;
      if (cl_req && !cl_we) rd_sh_q <= wr_sh;
    end
  end

  assign mem_en    = cl_req;
  assign mem_we    = cl_req && cl_we;
  assign mem_addr  = cl_addr;
  assign wr_dbl    = {cl_wdata, cl_wdata} << wr_sh;
  assign mem_wdata = wr_dbl[2*DATA_W-1:DATA_W];
  assign rd_dbl    = {mem_rdata, mem_rdata} >> rd_sh_q;
  assign cl_rdata  = rd_dbl[DATA_W-1:0];

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_req && !cl_we) |=> cl_rvalid); // R3
  AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(cl_req && !cl_we) |=> !cl_rvalid); // R3
  AST_ZERO_ENTRY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_req && cl_we && fmap[cl_addr] == '0) |-> mem_wdata == cl_wdata); // R4
  AST_UPDATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fm_wr |=> fmap[$past(fm_addr)] == $past(fm_idx)); // R5
  AST_ZERO_SHIFT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_req && !cl_we && fmap[cl_addr] == '0) |=> cl_rdata == mem_rdata); // R6
endmodule

// File: tb/fault_shuffle_wrap_tb.sv
module fault_shuffle_wrap_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32, ADDR_W = 4, SEG_BITS = 2;
  localparam int SEG_W = DATA_W >> SEG_BITS;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic cl_req = 0, cl_we = 0, fm_wr = 0;
  logic [ADDR_W-1:0] cl_addr = 0, fm_addr = 0;
  logic [DATA_W-1:0] cl_wdata = 0, mem_rdata = 0;
  logic [SEG_BITS-1:0] fm_idx = 0;
  logic [DATA_W-1:0] cl_rdata, mem_wdata;
  logic cl_rvalid, mem_en, mem_we;
  logic [ADDR_W-1:0] mem_addr;

  int checks = 0, errors = 0;
  int mmap [DEPTH];
  logic [DATA_W-1:0] arr [DEPTH];
  logic [DATA_W-1:0] stuck_mask [DEPTH];
  logic [DATA_W-1:0] stuck_val [DEPTH];
  logic [DATA_W-1:0] logical [DEPTH];
  logic exp_valid = 0;
  logic [DATA_W-1:0] exp_data = 0, exp_logical = 0;
  logic bound_chk = 0;

  fault_shuffle_wrap #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cl_req(cl_req), .cl_we(cl_we), .cl_addr(cl_addr),
    .cl_wdata(cl_wdata), .cl_rdata(cl_rdata), .cl_rvalid(cl_rvalid), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .fm_wr(fm_wr), .fm_addr(fm_addr), .fm_idx(fm_idx));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en && mem_we)
      arr[mem_addr] <= (mem_wdata & ~stuck_mask[mem_addr]) | (stuck_val[mem_addr] & stuck_mask[mem_addr]);
    else if (mem_en)
      mem_rdata <= arr[mem_addr];
  end

  function automatic logic [DATA_W-1:0] rotl_ref(logic [DATA_W-1:0] x, int s);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[(i + s) % DATA_W] = x[i];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] rotr_ref(logic [DATA_W-1:0] x, int s);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = x[(i + s) % DATA_W];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(bit req, bit we, int addr, logic [DATA_W-1:0] wd,
                       bit fw = 0, int faddr = 0, int fidx = 0);
    longint diff;
    @(negedge clk);
    chk(cl_rvalid == exp_valid, "R3 rvalid", DATA_W'(cl_rvalid), DATA_W'(exp_valid));
    if (exp_valid) begin
      chk(cl_rdata == exp_data, "R3/R6 rdata", cl_rdata, exp_data);
      if (bound_chk) begin
        diff = longint'($signed(cl_rdata)) - longint'($signed(exp_logical));
        if (diff < 0) diff = -diff;
        chk(diff < (64'd1 << SEG_W), "R7 error bound", cl_rdata, exp_logical);
      end
    end
    cl_req = req; cl_we = we; cl_addr = ADDR_W'(addr); cl_wdata = wd;
    fm_wr = fw; fm_addr = ADDR_W'(faddr); fm_idx = SEG_BITS'(fidx);
    #1;
    chk(mem_en == req, "R2 mem_en", DATA_W'(mem_en), DATA_W'(req));
    if (req) chk(mem_addr == ADDR_W'(addr), "R2 mem_addr", DATA_W'(mem_addr), DATA_W'(addr));
    if (req && we) begin
      chk(mem_wdata == rotl_ref(wd, mmap[addr] * SEG_W),
          mmap[addr] == 0 ? "R4 write identity" : "R2 write rotate",
          mem_wdata, rotl_ref(wd, mmap[addr] * SEG_W));
      logical[addr] = wd;
    end
    exp_valid = req && !we;
    if (req && !we) begin
      exp_data = rotr_ref(arr[addr], mmap[addr] * SEG_W);
      exp_logical = logical[addr];
      bound_chk = (stuck_mask[addr] != 0) && (mmap[addr] > 0);
    end
    if (fw) mmap[faddr] = fidx;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mmap[i] = 0; arr[i] = '0; stuck_mask[i] = '0; stuck_val[i] = '0; logical[i] = '0;
    end
    stuck_mask[5] = 32'h2000_0000; stuck_val[5] = 32'h2000_0000;
    stuck_mask[6] = 32'h2000_0000; stuck_val[6] = 32'h2000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cl_rvalid == 0, "R1 rvalid after reset", DATA_W'(cl_rvalid), 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) cycle(1, 1, a, 32'h1234_5678 ^ DATA_W'(a));
    for (int a = 0; a < 4; a++) cycle(1, 0, a, 0);
    cycle(1, 1, 1, 32'hA5C3_0F81, 1, 1, 1);
    cycle(1, 1, 1, 32'hA5C3_0F81);
    cycle(1, 0, 1, 0, 1, 1, 3);
    cycle(0, 0, 0, 0);
    cycle(1, 0, 1, 0);
    cycle(1, 1, 1, 32'h8000_0001);
    cycle(1, 0, 1, 0);
    for (int a = 8; a < 12; a++) cycle(0, 0, 0, 0, 1, a, a - 8);
    for (int a = 8; a < 12; a++) cycle(1, 1, a, 32'hDEAD_BEEF + DATA_W'(a * 977));
    for (int a = 8; a < 12; a++) cycle(1, 0, a, 0);
    cycle(0, 0, 0, 0, 1, 5, 29 / SEG_W);
    for (int k = 0; k < 6; k++) begin
      logic [DATA_W-1:0] v = (k % 2 == 0) ? -(DATA_W'(k * 12345 + 7)) : DATA_W'(k * 99991);
      cycle(1, 1, 5, v);
      cycle(1, 0, 5, 0);
      cycle(1, 1, 6, v);
      cycle(1, 0, 6, 0);
    end
    cycle(0, 0, 0, 0);
    cycle(0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule